// File: doc/BRIEF.md
# Fast Ethernet Receive Decoder

This block turns the recovered serial bit stream of a 100 Mb/s twisted-pair link into the MII receive nibble interface. The equalizer and clock recovery ahead of it deliver one NRZ bit per cycle of the bit clock. The block takes it from there. It synchronises a self-locking descrambler onto the idle stream and finds code-group boundaries from the start-of-stream delimiter. It maps each 5-bit group to a 4-bit nibble and raises an error flag when coding goes wrong, either inside a frame or in the idle gap between frames.

A divide-by-five phase counter sets the nibble rate and also forms the receive clock output. Carrier sense and collision combine receive activity with a transmit-activity input. A station/repeater input selects whether transmit activity counts toward carrier sense. When the PHY mode input selects a mode other than 100BASE-TX, every MII receive output floats.

Top module: `fe_rx_pcs`

## Requirements
- R1: Each 5-bit code group inside a frame is decoded to its 4-bit value on `rxd`, using the standard 4B/5B data table (for example 11110 gives 0 and 01001 gives 1). Group bits are transmitted leftmost first.
- R2: `rx_dv` is high for exactly the data groups of a frame. It stays low during idle and after the end-of-stream group 01101, and the following 00111 group is consumed.
- R3: A group inside a frame that is not a data code, end delimiter or idle produces `rx_er`=1 with `rx_dv`=1 for that nibble. The frame then continues.
- R4: In the idle gap, a zero bit that is not followed by the delimiter pair 11000 10001 produces one nibble with `rx_er`=1, `rx_dv`=0 and `rxd`=1110.
- R5: One idle group (11111) inside a frame gives `rx_er`=1 with `rx_dv`=1. A second consecutive idle group ends the frame with `rx_dv`=0.
- R6: `col` is high only while receive and transmit activity are both present.
- R7: In station mode (`repeater_mode`=0), `crs` is high when either receive or transmit activity is present.
- R8: In repeater mode (`repeater_mode`=1), `crs` follows receive activity only.
- R9: With `tx100_sel`=0, `rxd`, `rx_dv`, `rx_er`, `crs`, `col` and `rx_clk` are in high impedance.
- R10: The descrambler (key recurrence k[n]=k[n-11]^k[n-9]) locks only after LOCK_BITS consecutive bits consistent with scrambled idle. It drops lock after TIMEOUT_BITS bits without a run of IDLE_RUN descrambled ones, and it relocks on fresh idle. No data or error is reported while unlocked.
- R11: Outputs change once per five bit clocks, and `rx_clk` has a period of five bit clocks during idle.
- R12: After reset, `rx_dv`, `rx_er`, `crs` and `col` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered scrambled NRZ bit |
| tx_active | input | 1 | Transmit activity from the transmit path |
| repeater_mode | input | 1 | 1 selects repeater carrier-sense behaviour |
| tx100_sel | input | 1 | 1 when 100BASE-TX is the selected mode |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| rx_clk | output | 1 | Nibble-rate receive clock |

## Verification
The bench builds the block with LOCK_BITS=40, IDLE_RUN=30 and TIMEOUT_BITS=600. With these values, initial lock happens within a short idle preamble. Loss of lock and relock also fit in about a thousand bit clocks: the bench jumps its scrambler to a different state, and the resulting descrambled garbage never holds a run of thirty ones. Random frames use lengths of 4 to 23 nibbles, well inside the timeout window, so a locked receiver never times out during legitimate traffic.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

    localparam int GRP_W = 5;
    localparam int NIB_W = 4;

    localparam logic [4:0] CG_IDLE = 5'b11111;
    localparam logic [4:0] CG_SSD1 = 5'b11000;
    localparam logic [4:0] CG_SSD2 = 5'b10001;
    localparam logic [4:0] CG_ESD1 = 5'b01101;
    localparam logic [9:0] CG_SSD  = {CG_SSD1, CG_SSD2};
    localparam logic [3:0] FALSE_CARRIER = 4'b1110;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_CAND,
        FR_PKT,
        FR_END
    } frm_state_e;

    typedef struct packed {
        logic             ok;
        logic [NIB_W-1:0] nib;
    } dec_t;

    typedef struct packed {
        logic [NIB_W-1:0] rxd;
        logic             dv;
        logic             er;
    } mii_rx_t;

    function automatic dec_t decode5(input logic [GRP_W-1:0] g);
        dec_t d;
        d.ok = 1'b1;
        case (g)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            default: begin
                d.ok  = 1'b0;
                d.nib = 4'h0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fe_rx_descram.sv
module fe_rx_descram #(
    parameter int LOCK_BITS    = 60,
    parameter int IDLE_RUN     = 30,
    parameter int TIMEOUT_BITS = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic s_bit,
    output logic p_bit,
    output logic p_vld
);
    localparam int KEY_W = 11;
    localparam int CW    = $clog2(LOCK_BITS + 1);
    localparam int RW    = $clog2(IDLE_RUN + 1);
    localparam int TW    = $clog2(TIMEOUT_BITS + 1);

    logic [KEY_W-1:0] lfsr;
    logic             locked;
    logic [CW-1:0]    mcnt;
    logic [RW-1:0]    run;
    logic [TW-1:0]    tmr;
    logic             key;
    logic             plain;

    assign key   = lfsr[10] ^ lfsr[8];
    assign plain = s_bit ^ key;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr   <= '0;
            locked <= 1'b0;
            mcnt   <= '0;
            run    <= '0;
            tmr    <= '0;
            p_bit  <= 1'b1;
            p_vld  <= 1'b0;
        end else if (!locked) begin
            lfsr  <= {lfsr[KEY_W-2:0], ~s_bit};
            p_vld <= 1'b0;
            if (~s_bit == key) begin
                if (mcnt == CW'(LOCK_BITS - 1)) begin
                    locked <= 1'b1;
                    mcnt   <= '0;
                    tmr    <= '0;
                    run    <= '0;
                end else begin
                    mcnt <= mcnt + 1'b1;
                end
            end else begin
                mcnt <= '0;
            end
        end else begin
            lfsr  <= {lfsr[KEY_W-2:0], key};
            p_bit <= plain;
            p_vld <= 1'b1;
            if (plain) begin
                if (run != RW'(IDLE_RUN)) run <= run + 1'b1;
            end else begin
                run <= '0;
            end
            if (plain && run >= RW'(IDLE_RUN - 1)) begin
                tmr <= '0;
            end else if (tmr == TW'(TIMEOUT_BITS - 1)) begin
                locked <= 1'b0;
                tmr    <= '0;
                mcnt   <= '0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        tmr < TW'(TIMEOUT_BITS)); // R10

    AST_UNLOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !p_vld); // R10

endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer
    import fe_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    p_bit,
    input  logic    p_vld,
    output mii_rx_t out_q,
    output logic    rx_act,
    output logic    rx_clk
);
    frm_state_e st, st_n;
    logic [9:0] sh, sh_n;
    logic [2:0] ph, ph_n;
    logic [2:0] cc, cc_n;
    logic       pend, pend_n;
    logic       idl, idl_n;
    mii_rx_t    out_n;
    logic [4:0] grp;
    logic       at_bnd;
    dec_t       dec;

    always_comb begin
        sh_n   = {sh[8:0], p_bit};
        grp    = sh_n[4:0];
        at_bnd = (ph == 3'd4);
        ph_n   = at_bnd ? 3'd0 : ph + 3'd1;
        dec    = decode5(grp);
        st_n   = st;
        cc_n   = cc;
        pend_n = pend;
        idl_n  = idl;
        out_n  = out_q;
        if (!p_vld) begin
            st_n   = FR_IDLE;
            pend_n = 1'b0;
            idl_n  = 1'b0;
            out_n  = '0;
        end else begin
            case (st)
                FR_IDLE, FR_CAND: begin
                    if (at_bnd) begin
                        out_n.dv  = 1'b0;
                        out_n.er  = pend;
                        out_n.rxd = pend ? FALSE_CARRIER : 4'h0;
                        pend_n    = 1'b0;
                    end
                    if (st == FR_IDLE) begin
                        if (!p_bit) begin
                            st_n = FR_CAND;
                            cc_n = 3'd0;
                        end
                    end else if (cc == 3'd6) begin
                        if (sh_n == CG_SSD) begin
                            st_n  = FR_PKT;
                            ph_n  = 3'd0;
                            idl_n = 1'b0;
                        end else begin
                            st_n   = FR_IDLE;
                            pend_n = 1'b1;
                        end
                    end else begin
                        cc_n = cc + 3'd1;
                    end
                end
                FR_PKT: begin
                    if (at_bnd) begin
                        if (dec.ok) begin
                            out_n = '{rxd: dec.nib, dv: 1'b1, er: 1'b0};
                            idl_n = 1'b0;
                        end else if (grp == CG_ESD1) begin
                            out_n.dv = 1'b0;
                            out_n.er = 1'b0;
                            st_n     = FR_END;
                        end else if (grp == CG_IDLE) begin
                            if (idl) begin
                                out_n.dv = 1'b0;
                                out_n.er = 1'b0;
                                idl_n    = 1'b0;
                                st_n     = FR_IDLE;
                            end else begin
                                idl_n    = 1'b1;
                                out_n.dv = 1'b1;
                                out_n.er = 1'b1;
                            end
                        end else begin
                            out_n.dv = 1'b1;
                            out_n.er = 1'b1;
                        end
                    end
                end
                default: begin
                    if (at_bnd) begin
                        st_n     = FR_IDLE;
                        out_n.dv = 1'b0;
                        out_n.er = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FR_IDLE;
            sh    <= '1;
            ph    <= '0;
            cc    <= '0;
            pend  <= 1'b0;
            idl   <= 1'b0;
            out_q <= '0;
        end else begin
            st    <= st_n;
            sh    <= sh_n;
            ph    <= ph_n;
            cc    <= cc_n;
            pend  <= pend_n;
            idl   <= idl_n;
            out_q <= out_n;
        end
    end

    assign rx_act = (st == FR_PKT);
    assign rx_clk = (ph >= 3'd2);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ph <= 3'd4); // R11

    AST_NIBBLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph != 3'd0 && p_vld && $past(p_vld)) |-> $stable(out_q)); // R2

    AST_FALSE_CARRIER: assert property (@(posedge clk) disable iff (rst)
        (out_q.er && !out_q.dv) |-> out_q.rxd == FALSE_CARRIER); // R4

    AST_NO_DV_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !p_vld |=> !out_q.dv); // R10

endmodule

// File: rtl/fe_rx_carrier.sv
module fe_rx_carrier (
    input  logic rx_act,
    input  logic tx_active,
    input  logic repeater_mode,
    output logic crs,
    output logic col
);
    assign col = rx_act & tx_active;
    assign crs = rx_act | (tx_active & ~repeater_mode);
endmodule

// File: rtl/fe_rx_pcs.sv
module fe_rx_pcs
    import fe_rx_pkg::*;
#(
    parameter int LOCK_BITS    = 60,
    parameter int IDLE_RUN     = 30,
    parameter int TIMEOUT_BITS = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       tx_active,
    input  logic       repeater_mode,
    input  logic       tx100_sel,
    output logic [3:0] rxd,
    output logic       rx_dv,
    output logic       rx_er,
    output logic       crs,
    output logic       col,
    output logic       rx_clk
);
    logic    p_bit, p_vld;
    mii_rx_t mii;
    logic    rx_act, rclk_i, crs_i, col_i;

    fe_rx_descram #(
        .LOCK_BITS   (LOCK_BITS),
        .IDLE_RUN    (IDLE_RUN),
        .TIMEOUT_BITS(TIMEOUT_BITS)
    ) u_descram (
        .clk  (clk),
        .rst  (rst),
        .s_bit(rx_bit),
        .p_bit(p_bit),
        .p_vld(p_vld)
    );

    fe_rx_framer u_framer (
        .clk   (clk),
        .rst   (rst),
        .p_bit (p_bit),
        .p_vld (p_vld),
        .out_q (mii),
        .rx_act(rx_act),
        .rx_clk(rclk_i)
    );

    fe_rx_carrier u_carrier (
        .rx_act       (rx_act),
        .tx_active    (tx_active),
        .repeater_mode(repeater_mode),
        .crs          (crs_i),
        .col          (col_i)
    );

    assign rxd    = tx100_sel ? mii.rxd : 4'bzzzz;
    assign rx_dv  = tx100_sel ? mii.dv  : 1'bz;
    assign rx_er  = tx100_sel ? mii.er  : 1'bz;
    assign crs    = tx100_sel ? crs_i   : 1'bz;
    assign col    = tx100_sel ? col_i   : 1'bz;
    assign rx_clk = tx100_sel ? rclk_i  : 1'bz;

    AST_COL_HAS_CRS: assert property (@(posedge clk) disable iff (rst)
        col_i |-> crs_i); // R6

    AST_REPEATER_CRS: assert property (@(posedge clk) disable iff (rst)
        (repeater_mode && !rx_act) |-> !crs_i); // R8

    AST_STATION_TX_CRS: assert property (@(posedge clk) disable iff (rst)
        (!repeater_mode && tx_active) |-> crs_i); // R7

endmodule

// File: tb/test_fe_rx_pcs.sv
module test_fe_rx_pcs;
    localparam int CLK_PERIOD = 8;
    localparam int LOCKB = 40;
    localparam int RUNB  = 30;
    localparam int TMOB  = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b1;
    logic tx_active = 1'b0;
    logic repeater_mode = 1'b0;
    logic tx100_sel = 1'b1;
    wire [3:0] rxd;
    wire rx_dv, rx_er, crs, col, rx_clk;

    fe_rx_pcs #(.LOCK_BITS(LOCKB), .IDLE_RUN(RUNB), .TIMEOUT_BITS(TMOB)) i_fe_rx_pcs (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .tx_active(tx_active),
        .repeater_mode(repeater_mode), .tx100_sel(tx100_sel),
        .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs), .col(col), .rx_clk(rx_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    int cyc = 0, last_rise = 0, period = 0;
    int rx_n = 0, er_dv = 0, er_nodv = 0, col_seen = 0, crs_seen = 0, dv_any = 0, z_bad = 0;
    logic [3:0] err_rxd = 4'h0;
    logic prev_rc = 1'b0;
    logic [3:0] rbuf [0:63];
    logic [3:0] pay  [0:63];
    logic [10:0] scr = 11'h5A5;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rx_n = 0; er_dv = 0; er_nodv = 0; col_seen = 0; crs_seen = 0; dv_any = 0; z_bad = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rx_clk === 1'b1 && prev_rc !== 1'b1) begin
            period = cyc - last_rise;
            last_rise = cyc;
            if (rx_dv === 1'b1 && rx_er === 1'b0 && rx_n < 64) begin
                rbuf[rx_n] = rxd;
                rx_n++;
            end
            if (rx_er === 1'b1 && rx_dv === 1'b1) er_dv++;
            if (rx_er === 1'b1 && rx_dv === 1'b0) begin
                er_nodv++;
                err_rxd = rxd;
            end
        end
        prev_rc = rx_clk;
        if (col === 1'b1) col_seen++;
        if (crs === 1'b1) crs_seen++;
        if (rx_dv === 1'b1) dv_any++;
        if (tx100_sel == 1'b0 && (crs === 1'b1 || col === 1'b1 || rx_dv === 1'b1 ||
            rx_er === 1'b1 || rx_clk === 1'b1 || rxd[0] === 1'b1 || rxd[1] === 1'b1 ||
            rxd[2] === 1'b1 || rxd[3] === 1'b1)) z_bad++;
    end

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic send_plain(input logic b);
        logic k;
        @(negedge clk);
        k = scr[10] ^ scr[8];
        rx_bit = b ^ k;
        scr = {scr[9:0], k};
    endtask

    task automatic send_code(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_plain(c[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_plain(1'b1);
    endtask

    task automatic send_pkt(input int len, input int bad_pos);
        send_code(5'b11000);
        send_code(5'b10001);
        for (int i = 0; i < len; i++) begin
            if (i == bad_pos) send_code(5'b00000);
            else send_code(enc(pay[i]));
        end
        send_code(5'b01101);
        send_code(5'b00111);
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) pay[i] = 4'($urandom);
    endtask

    function automatic int mism(input int len, input int skip);
        int m = 0, j = 0;
        for (int i = 0; i < len; i++) begin
            if (i != skip) begin
                if (rbuf[j] !== pay[i]) m++;
                j++;
            end
        end
        return m;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int len;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R12 reset state
        chk(rx_dv === 1'b0 && rx_er === 1'b0, "R12 dv/er in reset", {rx_dv, rx_er}, 0);
        chk(crs === 1'b0 && col === 1'b0, "R12 crs/col in reset", {crs, col}, 0);
        rst = 1'b0;
        clear_mon();
        send_idle(200);
        chk(period == 5, "R11 rx_clk period", period, 5);
        chk(dv_any == 0 && er_dv == 0 && er_nodv == 0, "R10 quiet while locking on idle",
            dv_any + er_dv + er_nodv, 0);

        // R1 R2 random frames
        for (int p = 0; p < 6; p++) begin
            len = 4 + int'($urandom % 20);
            fill(len);
            clear_mon();
            send_pkt(len, -1);
            send_idle(40 + int'($urandom % 20));
            chk(rx_n == len, "R2 data nibble count", rx_n, len);
            chk(mism(len, -1) == 0, "R1 nibble values", mism(len, -1), 0);
            chk(er_dv == 0 && er_nodv == 0, "R3 no error on clean frame", er_dv + er_nodv, 0);
            chk(rx_dv === 1'b0, "R2 dv low after end", int'(rx_dv), 0);
        end

        // R7 R8 carrier sense from transmit
        tx_active = 1'b1; repeater_mode = 1'b0;
        clear_mon(); send_idle(20);
        chk(crs_seen == 20 && col_seen == 0, "R7 station crs on tx", crs_seen, 20);
        repeater_mode = 1'b1;
        send_idle(2);
        clear_mon(); send_idle(20);
        chk(crs_seen == 0, "R8 repeater ignores tx", crs_seen, 0);
        tx_active = 1'b0;
        fill(8); clear_mon(); send_pkt(8, -1); send_idle(40);
        chk(crs_seen > 0 && col_seen == 0, "R8 repeater crs on rx", crs_seen, 1);
        // R6 collision
        repeater_mode = 1'b0; tx_active = 1'b1;
        fill(8); clear_mon(); send_pkt(8, -1); send_idle(40);
        chk(col_seen > 0, "R6 col on rx and tx", col_seen, 1);
        tx_active = 1'b0;
        send_idle(2);
        clear_mon(); send_idle(20);
        chk(col_seen == 0, "R6 no col without rx", col_seen, 0);

        // R3 invalid code in frame
        fill(8); clear_mon(); send_pkt(8, 3); send_idle(40);
        chk(er_dv == 1, "R3 in-frame error flagged", er_dv, 1);
        chk(rx_n == 7 && mism(8, 3) == 0, "R3 frame continues", rx_n, 7);

        // R5 premature end
        fill(3); clear_mon();
        send_code(5'b11000); send_code(5'b10001);
        for (int i = 0; i < 3; i++) send_code(enc(pay[i]));
        send_idle(60);
        chk(rx_n == 3 && er_dv == 1, "R5 first idle flagged", er_dv, 1);
        chk(rx_dv === 1'b0, "R5 dv drops after second idle", int'(rx_dv), 0);

        // R4 corrupted idle
        clear_mon();
        send_plain(1); send_plain(1); send_plain(0);
        send_idle(47);
        chk(er_nodv == 1 && err_rxd == 4'hE, "R4 idle corruption", er_nodv, 1);
        chk(rx_n == 0 && dv_any == 0, "R4 no dv on idle corruption", dv_any, 0);

        // R10 loss of lock and relock
        scr = scr ^ 11'h001;
        send_idle(TMOB + 300);
        fill(10); clear_mon(); send_pkt(10, -1); send_idle(40);
        chk(rx_n == 10 && mism(10, -1) == 0, "R10 relock after desync", rx_n, 10);

        // R9 high impedance in other mode
        tx100_sel = 1'b0; tx_active = 1'b1;
        fill(8); clear_mon(); send_pkt(8, -1); send_idle(40);
        chk(z_bad == 0, "R9 outputs float", z_bad, 0);
        tx100_sel = 1'b1;
        send_idle(5);
        chk(crs === 1'b1, "R9 outputs return when selected", int'(crs), 1);
        tx_active = 1'b0;
        send_idle(10);
        finish_run();
    end
endmodule